// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Output Updates

This block is a bank of 32 general-purpose pins behind a simple single-port 32-bit register bus. It holds three things: a direction register, an output data latch and a synchronised copy of the pin inputs. Toward the pads it drives a per-pin drive enable and a per-pin output value. From the pads it takes one input level per pin.

Software changes single output bits without a read-modify-write. It writes a mask to a set port or to a clear port. Only the bits written as 1 change, so separate agents can update different pins without racing. The output latch can also be loaded in one write. A fixed revision word lets software identify the block.

Bus writes take effect at the rising clock edge on which `bus_wr` is high. Reads are combinational from the addressed register. The bus completes one access per cycle, so a set and a clear can never reach the same bit in the same cycle. Pin p corresponds to bit p of every per-pin register and port.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (all pins inputs), the output latch reads 0, and `pad_drive_en` is all zeros.
- R2: The direction register at offset 0x134 is read/write. A bit value of 1 makes its pin an input with the driver off (`pad_drive_en` bit 0). A bit value of 0 turns the driver on (`pad_drive_en` bit 1).
- R3: `pad_out` always equals the output latch.
- R4: A write to offset 0x194 sets every latch bit whose write-data bit is 1 and leaves the other bits unchanged. A write of 0 changes nothing.
- R5: A write to offset 0x190 clears every latch bit whose write-data bit is 1 and leaves the other bits unchanged. A write of 0 changes nothing.
- R6: Offset 0x13C reads the output latch. A write there replaces the whole latch with the write data.
- R7: Offset 0x138 reads the pin input levels through a two-flop synchroniser. A change on `pad_in` just before rising edge k is visible after edge k+1 and not after edge k.
- R8: Offset 0x000 reads the constant 0x50600801. Writes to it are ignored.
- R9: Reads of offsets other than 0x000, 0x134, 0x138 and 0x13C return 0. Writes to any offset other than 0x134, 0x13C, 0x190 and 0x194 (including 0x138) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pin input levels from the pads |
| pad_out | output | 32 | Output value to the pads |
| pad_drive_en | output | 32 | Per-pin driver enable (1 = drive) |

## Verification
The hardest point to reach is the behaviour of the set and clear ports when the write mask is mixed or all zeros. A port that handles these cases wrongly still passes any test that only writes all-ones masks. The stimulus therefore first loads the latch with an irregular pattern. It then applies masks that overlap some set bits and some clear bits, and after that zero masks, reading the latch back after each write. Synchroniser latency is checked edge by edge: the data-in register is read after the first edge, where the old value is expected, and again after the second edge.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int          NPINS    = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] REV_WORD = 32'h5060_0801
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_drive_en
);

  localparam logic [ADDR_W-1:0] OFF_REV  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'('h134);
  localparam logic [ADDR_W-1:0] OFF_DIN  = ADDR_W'('h138);
  localparam logic [ADDR_W-1:0] OFF_DOUT = ADDR_W'('h13C);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'('h190);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'('h194);

  logic [NPINS-1:0] dir_q, out_q, in_s1, in_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_DIR:  dir_q <= bus_wdata;
        OFF_DOUT: out_q <= bus_wdata;
        OFF_SET:  out_q <= out_q | bus_wdata;
        OFF_CLR:  out_q <= out_q & ~bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_s1 <= '0;
      in_s2 <= '0;
    end else begin
      in_s1 <= pad_in;
      in_s2 <= in_s1;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_REV:  bus_rdata = REV_WORD[NPINS-1:0];
      OFF_DIR:  bus_rdata = dir_q;
      OFF_DIN:  bus_rdata = in_s2;
      OFF_DOUT: bus_rdata = out_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_out      = out_q;
  assign pad_drive_en = ~dir_q;

  a_r4_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_SET |=> (pad_out & $past(bus_wdata)) == $past(bus_wdata));

  a_r4_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_SET |=> (pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata)));

  a_r5_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_CLR |=> (pad_out & $past(bus_wdata)) == '0);

  a_r5_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_CLR |=> (pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata)));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_DOUT |=> pad_out == $past(bus_wdata));

  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr != OFF_DIR && bus_addr != OFF_DOUT && bus_addr != OFF_SET && bus_addr != OFF_CLR
    |=> $stable(pad_out) && $stable(pad_drive_en));

  a_r8_rev_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == OFF_REV |-> bus_rdata == REV_WORD[NPINS-1:0]);

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_drive_en;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_drive_en(pad_drive_en)
  );

  // {is_read, offset, data (write data or expected read), requirement number}
  localparam int NV = 20;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 12'h134, 32'h0000_FFFF, 4'd2},
    {1'b1, 12'h134, 32'h0000_FFFF, 4'd2},  // R2
    {1'b0, 12'h13C, 32'hA5A5_A5A5, 4'd6},
    {1'b1, 12'h13C, 32'hA5A5_A5A5, 4'd6},  // R6
    {1'b0, 12'h194, 32'h0F0F_0000, 4'd4},
    {1'b1, 12'h13C, 32'hAFAF_A5A5, 4'd4},  // R4 mixed mask
    {1'b0, 12'h190, 32'h00FF_00FF, 4'd5},
    {1'b1, 12'h13C, 32'hAF00_A500, 4'd5},  // R5 mixed mask
    {1'b0, 12'h194, 32'h0000_0000, 4'd4},
    {1'b1, 12'h13C, 32'hAF00_A500, 4'd4},  // R4 zero mask
    {1'b0, 12'h190, 32'h0000_0000, 4'd5},
    {1'b1, 12'h13C, 32'hAF00_A500, 4'd5},  // R5 zero mask
    {1'b0, 12'h000, 32'hFFFF_FFFF, 4'd8},
    {1'b1, 12'h000, 32'h5060_0801, 4'd8},  // R8
    {1'b0, 12'h200, 32'hFFFF_FFFF, 4'd9},
    {1'b1, 12'h13C, 32'hAF00_A500, 4'd9},  // R9
    {1'b1, 12'h134, 32'h0000_FFFF, 4'd9},  // R9
    {1'b1, 12'h200, 32'h0000_0000, 4'd9},  // R9
    {1'b0, 12'h138, 32'hFFFF_FFFF, 4'd9},
    {1'b1, 12'h13C, 32'hAF00_A500, 4'd9}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h134, v); check("R1 dir reset", v, 32'hFFFF_FFFF);
    rd(12'h13C, v); check("R1 latch reset", v, 32'h0);
    check("R1 drive_en reset", pad_drive_en, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) begin
        rd(VEC[i][47:36], v);
        check($sformatf("R%0d table row %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
      end else begin
        wr(VEC[i][47:36], VEC[i][35:4]);
      end
    end

    check("R2 drive_en", pad_drive_en, 32'hFFFF_0000);
    check("R3 pad_out", pad_out, 32'hAF00_A500);
    wr(12'h194, 32'h0000_0001);
    check("R3 pad_out after set", pad_out, 32'hAF00_A501);
    wr(12'h190, 32'hFFFF_FFFF);
    check("R5 clear all", pad_out, 32'h0);
    wr(12'h134, 32'hFFFF_FFFF);
    check("R2 all inputs", pad_drive_en, 32'h0);

    // R7: two-stage synchroniser latency
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(12'h138, v); check("R7 after one edge", v, 32'h0);
    @(negedge clk);
    rd(12'h138, v); check("R7 after two edges", v, 32'h1234_5678);
    rd(12'h0F0, v); check("R9 unmapped read", v, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule